// File: doc/BRIEF.md
# Parallel Programming Command Sequencer

This block is the target side of a byte-wide parallel programming port. An external programmer presents a byte on `din` together with a two-bit load selector and pulses `cap_stb`. Each pulse stores the byte into one of four places: the command register, the low address byte, the high address byte or the data register. A pulse on `page_ld` copies the data register into a word-wide page buffer. The low address bits pick the buffer slot, and `byte_hi` picks which half of the word is written.

A falling edge on `wr_n` starts the operation named by the latched command. The block then holds `idle` low for a fixed number of reference clock cycles. That number depends on the operation: a single-byte write (data memory or configuration byte), a flash page write, or a chip erase. At launch the block takes a copy of the operation kind, the address and the data, so the programmer may load new values while the operation runs. Pulling `oe_n` low presents the byte chosen by a read command on `rd_data` and raises `rd_valid`. The reader controls `oe_n` and so needs no back-pressure. `rd_data` stays at zero whenever `rd_valid` is low.

All inputs are sampled on the rising edge of the reference clock `clk`. Strobe edges are found by comparing each input with its value one cycle earlier.

Top module: `pp_sequencer`

## Requirements
- R1: After reset, `idle` is 1, `rd_valid` is 0 and `rd_data` is 0. Every flash word reads 16'hFFFF, every data-memory byte reads 8'hFF and the configuration byte reads 8'hFF.
- R2: A rising edge of `cap_stb` stores `din` according to `load_sel`: 0 loads the command, 1 loads address bits 7:0, 2 loads address bits 15:8, 3 loads the data register.
- R3: A rising edge of `page_ld` copies the data register into the page-buffer slot given by the low log2(PAGE_WORDS) address bits. `byte_hi`=1 writes bits 15:8 of that slot and `byte_hi`=0 writes bits 7:0.
- R4: Suppose a falling edge of `wr_n` is sampled while `idle` is 1 and the command is a write code. Write codes are 8'h80 chip erase, 8'h10 flash page write, 8'h11 data-memory byte write and 8'h40 configuration byte write. Then `idle` is 0 from the next cycle, and `idle` never falls without such an edge.
- R5: `idle` stays low for exactly T_BYTE_US*CLK_KHZ/1000 cycles for byte writes, T_FLASH_US*CLK_KHZ/1000 cycles for a flash page write and T_ERASE_US*CLK_KHZ/1000 cycles for chip erase.
- R6: A flash page write copies the whole page buffer into the flash page selected by the address bits above the slot bits.
- R7: A data-memory byte write stores the data register at the address in the low log2(EE_BYTES) bits. A configuration byte write replaces the configuration byte.
- R8: Chip erase sets every flash word to 16'hFFFF and every data-memory byte to 8'hFF, and leaves the configuration byte unchanged.
- R9: A `wr_n` falling edge while `idle` is 0 does not restart or lengthen the operation. A `wr_n` falling edge with a non-write command never lowers `idle`.
- R10: When `oe_n` is sampled low, the next cycle shows `rd_valid`=1 and a `rd_data` value chosen by the command. 8'h02 reads the flash word at the address, with `byte_hi` choosing the upper half. 8'h03 reads the data-memory byte. 8'h04 reads the configuration byte. Any other command reads 0. When `oe_n` is sampled high, the next cycle shows `rd_valid`=0 and `rd_data`=0.
- R11: Changes to the address, data register or command made while `idle` is 0 do not alter the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also times operations |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_stb | input | 1 | Capture strobe; rising edge stores `din` |
| load_sel | input | 2 | Destination of a capture (command, address low, address high, data) |
| din | input | 8 | Byte presented by the programmer |
| page_ld | input | 1 | Page-buffer load strobe |
| byte_hi | input | 1 | Selects the upper byte of a word for page loads and flash reads |
| wr_n | input | 1 | Active-low write pulse; its falling edge launches an operation |
| oe_n | input | 1 | Active-low output enable for reads |
| idle | output | 1 | High when no operation is running |
| rd_data | output | 8 | Read byte, zero when not enabled |
| rd_valid | output | 1 | Read data present on `rd_data` |

## Verification
The bench builds the block with CLK_KHZ=1000 and windows of 5, 9 and 13 µs, so the three busy lengths are 5, 9 and 13 cycles. Every operation can therefore be timed cycle by cycle, and all three windows are told apart within a short run. The memories keep their 64-word flash (8-word pages) and 32-byte data-memory defaults. At that size the bench can read back every flash word in both halves and every data byte after reset, after a page write and after an erase. It can also write each data-memory address once with an arithmetic pattern.

// File: rtl/pp_pkg.sv
package pp_pkg;

  typedef enum logic [1:0] {
    LD_CMD     = 2'd0,
    LD_ADDR_LO = 2'd1,
    LD_ADDR_HI = 2'd2,
    LD_DATA    = 2'd3
  } load_sel_e;

  typedef enum logic [1:0] {
    OP_EE    = 2'd0,
    OP_FUSE  = 2'd1,
    OP_FLASH = 2'd2,
    OP_ERASE = 2'd3
  } op_e;

  localparam logic [7:0] CMD_ERASE    = 8'h80;
  localparam logic [7:0] CMD_WR_FLASH = 8'h10;
  localparam logic [7:0] CMD_WR_EE    = 8'h11;
  localparam logic [7:0] CMD_WR_FUSE  = 8'h40;
  localparam logic [7:0] CMD_RD_FLASH = 8'h02;
  localparam logic [7:0] CMD_RD_EE    = 8'h03;
  localparam logic [7:0] CMD_RD_FUSE  = 8'h04;

  typedef struct packed {
    op_e         op;
    logic [15:0] addr;
    logic [7:0]  data;
  } job_t;

  function automatic logic is_write_cmd(input logic [7:0] c);
    return (c == CMD_ERASE) || (c == CMD_WR_FLASH) ||
           (c == CMD_WR_EE) || (c == CMD_WR_FUSE);
  endfunction

  function automatic op_e cmd_to_op(input logic [7:0] c);
    case (c)
      CMD_ERASE:    return OP_ERASE;
      CMD_WR_FLASH: return OP_FLASH;
      CMD_WR_FUSE:  return OP_FUSE;
      default:      return OP_EE;
    endcase
  endfunction

endpackage

// File: rtl/pp_capture.sv
module pp_capture
  import pp_pkg::*;
#(
  parameter int PAGE_WORDS = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cap_stb,
  input  logic [1:0]                   load_sel,
  input  logic [7:0]                   din,
  input  logic                         page_ld,
  input  logic                         byte_hi,
  output logic [7:0]                   cmd_q,
  output logic [15:0]                  addr_q,
  output logic [7:0]                   data_q,
  output logic [PAGE_WORDS-1:0][15:0]  page_q
);

  localparam int PG_W = $clog2(PAGE_WORDS);

  logic stb_d, pl_d;
  logic cap_rise, pl_rise;

  assign cap_rise = cap_stb & ~stb_d;
  assign pl_rise  = page_ld & ~pl_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_d  <= 1'b0;
      pl_d   <= 1'b0;
      cmd_q  <= 8'h00;
      addr_q <= 16'h0000;
      data_q <= 8'h00;
    end else begin
      stb_d <= cap_stb;
      pl_d  <= page_ld;
      if (cap_rise) begin
        case (load_sel_e'(load_sel))
          LD_CMD:     cmd_q        <= din;
          LD_ADDR_LO: addr_q[7:0]  <= din;
          LD_ADDR_HI: addr_q[15:8] <= din;
          LD_DATA:    data_q       <= din;
          default:    ;
        endcase
      end
    end
  end

  // One register pair per page slot; each slot decodes its own index.
  for (genvar g = 0; g < PAGE_WORDS; g++) begin : g_slot
    logic [15:0] word_q;
    logic        hit;
    assign hit = pl_rise && (addr_q[PG_W-1:0] == PG_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q <= 16'hFFFF;
      end else if (hit) begin
        if (byte_hi) word_q[15:8] <= data_q;
        else         word_q[7:0]  <= data_q;
      end
    end
    assign page_q[g] = word_q;
  end

endmodule

// File: rtl/pp_timer.sv
module pp_timer
  import pp_pkg::*;
#(
  parameter int T_BYTE  = 4,
  parameter int T_FLASH = 8,
  parameter int T_ERASE = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  op_e  op,
  output logic busy,
  output logic done
);

  localparam int T_MAX0 = (T_BYTE > T_FLASH) ? T_BYTE : T_FLASH;
  localparam int T_MAX  = (T_MAX0 > T_ERASE) ? T_MAX0 : T_ERASE;
  localparam int CNT_W  = $clog2(T_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] dur;

  always_comb begin
    case (op)
      OP_FLASH: dur = CNT_W'(T_FLASH - 1);
      OP_ERASE: dur = CNT_W'(T_ERASE - 1);
      default:  dur = CNT_W'(T_BYTE - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        busy <= 1'b1;
        cnt  <= dur;
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pp_store.sv
module pp_store
  import pp_pkg::*;
#(
  parameter int FLASH_WORDS = 64,
  parameter int PAGE_WORDS  = 8,
  parameter int EE_BYTES    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        commit,
  input  job_t                        job,
  input  logic [PAGE_WORDS-1:0][15:0] page,
  input  logic [7:0]                  rd_cmd,
  input  logic [15:0]                 rd_addr,
  input  logic                        rd_hi,
  input  logic                        oe_n,
  output logic [7:0]                  rd_data,
  output logic                        rd_valid
);

  localparam int FA_W = $clog2(FLASH_WORDS);
  localparam int PG_W = $clog2(PAGE_WORDS);
  localparam int EA_W = $clog2(EE_BYTES);

  logic [15:0] flash_m [FLASH_WORDS];
  logic [7:0]  ee_m    [EE_BYTES];
  logic [7:0]  fuse_q;

  logic [FA_W-PG_W-1:0] pg_sel;
  logic [7:0]           sel_byte;
  logic                 unused_addr;

  assign pg_sel      = job.addr[FA_W-1:PG_W];
  assign unused_addr = ^{rd_addr, job.addr};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < FLASH_WORDS; i++) flash_m[i] <= 16'hFFFF;
      for (int i = 0; i < EE_BYTES; i++)    ee_m[i]    <= 8'hFF;
      fuse_q <= 8'hFF;
    end else if (commit) begin
      case (job.op)
        OP_FLASH: begin
          for (int i = 0; i < PAGE_WORDS; i++)
            flash_m[{pg_sel, PG_W'(i)}] <= page[i];
        end
        OP_EE:   ee_m[job.addr[EA_W-1:0]] <= job.data;
        OP_FUSE: fuse_q <= job.data;
        OP_ERASE: begin
          for (int i = 0; i < FLASH_WORDS; i++) flash_m[i] <= 16'hFFFF;
          for (int i = 0; i < EE_BYTES; i++)    ee_m[i]    <= 8'hFF;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    sel_byte = 8'h00;
    case (rd_cmd)
      CMD_RD_FLASH: sel_byte = rd_hi ? flash_m[rd_addr[FA_W-1:0]][15:8]
                                     : flash_m[rd_addr[FA_W-1:0]][7:0];
      CMD_RD_EE:    sel_byte = ee_m[rd_addr[EA_W-1:0]];
      CMD_RD_FUSE:  sel_byte = fuse_q;
      default:      sel_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else if (!oe_n) begin
      rd_valid <= 1'b1;
      rd_data  <= sel_byte;
    end else begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end
  end

endmodule

// File: rtl/pp_sequencer.sv
module pp_sequencer
  import pp_pkg::*;
#(
  parameter int CLK_KHZ     = 8000,
  parameter int T_BYTE_US   = 1350,
  parameter int T_FLASH_US  = 11000,
  parameter int T_ERASE_US  = 22000,
  parameter int FLASH_WORDS = 64,
  parameter int PAGE_WORDS  = 8,
  parameter int EE_BYTES    = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_stb,
  input  logic [1:0] load_sel,
  input  logic [7:0] din,
  input  logic       page_ld,
  input  logic       byte_hi,
  input  logic       wr_n,
  input  logic       oe_n,
  output logic       idle,
  output logic [7:0] rd_data,
  output logic       rd_valid
);

  localparam int T_BYTE_CYC  = CLK_KHZ * T_BYTE_US / 1000;
  localparam int T_FLASH_CYC = CLK_KHZ * T_FLASH_US / 1000;
  localparam int T_ERASE_CYC = CLK_KHZ * T_ERASE_US / 1000;

  logic [7:0]                  cmd_q;
  logic [15:0]                 addr_q;
  logic [7:0]                  data_q;
  logic [PAGE_WORDS-1:0][15:0] page_q;

  logic wr_d, wr_fall, launch, busy, done;
  job_t job_q;

  pp_capture #(.PAGE_WORDS(PAGE_WORDS)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .load_sel(load_sel),
    .din(din), .page_ld(page_ld), .byte_hi(byte_hi),
    .cmd_q(cmd_q), .addr_q(addr_q), .data_q(data_q), .page_q(page_q)
  );

  assign wr_fall = wr_d & ~wr_n;
  assign launch  = wr_fall & ~busy & is_write_cmd(cmd_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_d  <= 1'b1;
      job_q <= '0;
    end else begin
      wr_d <= wr_n;
      if (launch) job_q <= '{op: cmd_to_op(cmd_q), addr: addr_q, data: data_q};
    end
  end

  pp_timer #(
    .T_BYTE(T_BYTE_CYC), .T_FLASH(T_FLASH_CYC), .T_ERASE(T_ERASE_CYC)
  ) u_tmr (
    .clk(clk), .rst_n(rst_n), .launch(launch), .op(cmd_to_op(cmd_q)),
    .busy(busy), .done(done)
  );

  pp_store #(
    .FLASH_WORDS(FLASH_WORDS), .PAGE_WORDS(PAGE_WORDS), .EE_BYTES(EE_BYTES)
  ) u_mem (
    .clk(clk), .rst_n(rst_n), .commit(done), .job(job_q), .page(page_q),
    .rd_cmd(cmd_q), .rd_addr(addr_q), .rd_hi(byte_hi), .oe_n(oe_n),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assign idle = ~busy;

endmodule

// File: rtl/pp_sequencer_chk.sv
module pp_sequencer_chk
  import pp_pkg::*;
#(
  parameter int T_BYTE_CYC  = 1,
  parameter int T_FLASH_CYC = 1,
  parameter int T_ERASE_CYC = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_n,
  input logic       oe_n,
  input logic       idle,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic [7:0] cmd
);

  logic        wr_prev;
  logic        edge_seen;
  int unsigned low_len;

  assign edge_seen = wr_prev & ~wr_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_prev <= 1'b1;
      low_len <= 0;
    end else begin
      wr_prev <= wr_n;
      low_len <= idle ? 0 : low_len + 1;
    end
  end

  a_r4_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && idle && is_write_cmd(cmd)) |=> !idle);

  a_r4_fall_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle) |-> $past(edge_seen));

  a_r9_nonwrite_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && idle && !is_write_cmd(cmd)) |=> idle);

  a_r5_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> (low_len == T_BYTE_CYC || low_len == T_FLASH_CYC ||
                     low_len == T_ERASE_CYC));

  a_r10_oe_on: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |=> rd_valid);

  a_r10_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> (!rd_valid && rd_data == 8'h00));

endmodule

bind pp_sequencer pp_sequencer_chk #(
  .T_BYTE_CYC(T_BYTE_CYC), .T_FLASH_CYC(T_FLASH_CYC), .T_ERASE_CYC(T_ERASE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .oe_n(oe_n), .idle(idle),
  .rd_valid(rd_valid), .rd_data(rd_data), .cmd(cmd_q)
);

// File: tb/pp_sequencer_test.sv
module pp_sequencer_test;

  localparam int KHZ = 1000, TB_US = 5, TF_US = 9, TE_US = 13;
  localparam int LEN_B = KHZ * TB_US / 1000;
  localparam int LEN_F = KHZ * TF_US / 1000;
  localparam int LEN_E = KHZ * TE_US / 1000;
  localparam int NW = 64, NP = 8, NE = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cap_stb = 1'b0, page_ld = 1'b0, byte_hi = 1'b0;
  logic wr_n = 1'b1, oe_n = 1'b1;
  logic [1:0] load_sel = 2'd0;
  logic [7:0] din = 8'h00;
  logic idle, rd_valid;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  pp_sequencer #(
    .CLK_KHZ(KHZ), .T_BYTE_US(TB_US), .T_FLASH_US(TF_US), .T_ERASE_US(TE_US),
    .FLASH_WORDS(NW), .PAGE_WORDS(NP), .EE_BYTES(NE)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .load_sel(load_sel),
    .din(din), .page_ld(page_ld), .byte_hi(byte_hi), .wr_n(wr_n),
    .oe_n(oe_n), .idle(idle), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] s, input logic [7:0] v);
    @(negedge clk); load_sel = s; din = v; cap_stb = 1'b1;
    @(negedge clk); cap_stb = 1'b0;
  endtask

  task automatic set_addr(input int a);
    load(2'd1, 8'(a));
    load(2'd2, 8'(a >> 8));
  endtask

  task automatic latch(input logic hi, input logic [7:0] v);
    load(2'd3, v);
    @(negedge clk); byte_hi = hi; page_ld = 1'b1;
    @(negedge clk); page_ld = 1'b0;
  endtask

  task automatic rd(input logic [7:0] c, input int a, input logic hi,
                    output logic [7:0] v);
    load(2'd0, c);
    set_addr(a);
    @(negedge clk); byte_hi = hi; oe_n = 1'b0;
    @(negedge clk); v = rd_data;
    check("R10 valid on", int'(rd_valid), 1);
    oe_n = 1'b1;
    @(negedge clk);
    check("R10 valid off", int'(rd_valid), 0);
    check("R10 bus zero", int'(rd_data), 0);
  endtask

  // wr_n low for one cycle; returns number of cycles idle was low
  task automatic run_op(input string req, output int n);
    @(negedge clk); wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    check({req, " R4 busy next cycle"}, int'(idle), 0);
    n = 1;
    while (!idle && n < 1000) begin
      @(negedge clk);
      if (!idle) n++;
    end
    repeat (2) @(negedge clk);
  endtask

  function automatic int pat_lo(input int i); return (i * 37 + 5) & 255; endfunction
  function automatic int pat_hi(input int i); return (i * 11 + 96) & 255; endfunction
  function automatic int ee_pat(input int a); return (a * 13 + 1) & 255; endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", int'(idle), 1);
    check("R1 rd_valid", int'(rd_valid), 0);
    check("R1 rd_data", int'(rd_data), 0);

    // R1: reset contents
    for (int w = 0; w < NW; w++) begin
      rd(8'h02, w, 1'b0, v); check("R1 flash lo", int'(v), 255);
      rd(8'h02, w, 1'b1, v); check("R1 flash hi", int'(v), 255);
    end
    for (int a = 0; a < NE; a++) begin
      rd(8'h03, a, 1'b0, v); check("R1 ee", int'(v), 255);
    end
    rd(8'h04, 0, 1'b0, v); check("R1 fuse", int'(v), 255);

    // R2/R3: fill page buffer through address + data captures
    for (int i = 0; i < NP; i++) begin
      set_addr(i);
      latch(1'b0, 8'(pat_lo(i)));
      latch(1'b1, 8'(pat_hi(i)));
    end
    // R6: flash page 2
    load(2'd0, 8'h10);
    set_addr(2 * NP);
    run_op("R5 flash", n);
    check("R5 flash length", n, LEN_F);
    for (int w = 0; w < NW; w++) begin
      rd(8'h02, w, 1'b0, v);
      check("R6 R3 flash lo", int'(v), (w / NP == 2) ? pat_lo(w % NP) : 255);
      rd(8'h02, w, 1'b1, v);
      check("R6 R3 flash hi", int'(v), (w / NP == 2) ? pat_hi(w % NP) : 255);
    end

    // R7: data-memory sweep
    for (int a = 0; a < NE; a++) begin
      load(2'd0, 8'h11);
      set_addr(a);
      load(2'd3, 8'(ee_pat(a)));
      run_op("R5 byte", n);
      check("R5 byte length", n, LEN_B);
    end
    for (int a = 0; a < NE; a++) begin
      rd(8'h03, a, 1'b0, v); check("R7 ee readback", int'(v), ee_pat(a));
    end
    load(2'd0, 8'h40);
    load(2'd3, 8'h5A);
    run_op("R5 fuse", n);
    check("R5 fuse length", n, LEN_B);
    rd(8'h04, 0, 1'b0, v); check("R7 fuse", int'(v), 8'h5A);

    // R9: non-write command never lowers idle
    load(2'd0, 8'h03);
    @(negedge clk); wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    n = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); if (!idle) n++;
    end
    check("R9 non-write ignored", n, 0);

    // R9: second write pulse during busy does not lengthen it
    load(2'd0, 8'h11);
    set_addr(3);
    load(2'd3, 8'h77);
    @(negedge clk); wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    n = idle ? 0 : 1;
    while (!idle && n < 1000) begin
      @(negedge clk);
      if (n == 2) wr_n = 1'b0;
      if (n == 3) wr_n = 1'b1;
      if (!idle) n++;
    end
    wr_n = 1'b1;
    check("R9 busy retrigger length", n, LEN_B);
    repeat (3) @(negedge clk);
    check("R9 idle stays after", int'(idle), 1);
    rd(8'h03, 3, 1'b0, v); check("R9 ee write done", int'(v), 8'h77);

    // R11: change data/address while busy
    load(2'd0, 8'h11);
    set_addr(4);
    load(2'd3, 8'h33);
    @(negedge clk); wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    load(2'd3, 8'hAA);
    set_addr(5);
    while (!idle) @(negedge clk);
    repeat (2) @(negedge clk);
    rd(8'h03, 4, 1'b0, v); check("R11 snapshot target", int'(v), 8'h33);
    rd(8'h03, 5, 1'b0, v); check("R11 other untouched", int'(v), ee_pat(5));

    // R8: chip erase
    load(2'd0, 8'h80);
    run_op("R5 erase", n);
    check("R5 erase length", n, LEN_E);
    for (int w = 0; w < NW; w++) begin
      rd(8'h02, w, 1'b0, v); check("R8 flash lo", int'(v), 255);
      rd(8'h02, w, 1'b1, v); check("R8 flash hi", int'(v), 255);
    end
    for (int a = 0; a < NE; a++) begin
      rd(8'h03, a, 1'b0, v); check("R8 ee", int'(v), 255);
    end
    rd(8'h04, 0, 1'b0, v); check("R8 fuse kept", int'(v), 8'h5A);
    rd(8'h55, 0, 1'b0, v); check("R10 unknown read zero", int'(v), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule